// File: doc/BRIEF.md
# Asynchronous Serial Character Receiver

This block takes one serial line that rests at logic 1 and turns each asynchronous character on it into a parallel byte. A clock enable pulsing sixteen times per bit interval paces it. A 0 on the line, seen on one of these pulses, is taken as a candidate start bit. The block looks at the line again half a bit later to reject noise. It then reads every later bit one whole bit interval after the one before, so each bit is read close to its centre.

The character format is chosen at run time: five to eight data bits sent least significant bit first, then an optional parity bit (even or odd), then one or two stop bits. The format is captured when a start bit is recognised, so changing it during a character has no effect on that character. At the last stop-bit sample the block gives a one-clock strobe with the character and two flags, one for parity and one for framing. After a framing error it waits until the line is seen at 1 before it looks for a new start bit. Each new start bit restarts its timing, so timing error does not build up from one character to the next.

Top module: `async_char_rx`

## Requirements
- R1: While reset is held, and after it is released, `char_valid`, `parity_err` and `frame_err` are 0 and `char_data` is 0x00 until the first character completes.
- R2: `cfg_data_bits` selects 5, 6, 7 or 8 data bits for the codes 0, 1, 2 and 3. The first data bit after the start bit lands in `char_data[0]`, and bits above the selected count read 0.
- R3: `cfg_parity` code 1 selects even parity and code 2 selects odd parity. Codes 0 and 3 mean that no parity bit is present. With parity enabled, `parity_err` is set with the strobe when the total number of ones in the data bits plus the parity bit is odd (even mode) or even (odd mode).
- R4: `cfg_two_stop` = 1 expects two stop bits and 0 expects one. `frame_err` is set with the strobe if any expected stop bit is sampled as 0.
- R5: A 0 on the line that is back at 1 by the mid-point of the start bit (8 oversample pulses after detection) produces no character.
- R6: `char_valid` is high for exactly one clock per character. `parity_err` and `frame_err` are only ever high in that same clock.
- R7: Bits are sampled at their centres: the strobe comes 8 + 16·(F−1) oversample pulses after the pulse on which the start bit was detected, where F is the total number of bit intervals in the character, counting the start bit.
- R8: After a character with a framing error, no new start bit is accepted until the line has been sampled at 1 on an oversample pulse. A line held at 0 produces no further characters.
- R9: Characters sent back to back, with each start bit directly after the previous stop element, are all received correctly.
- R10: The format inputs are captured when the start bit is detected. Changing them during a character does not alter how that character is received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| os_tick | input | 1 | Oversample enable, 16 pulses per bit interval |
| rxd_in | input | 1 | Asynchronous serial line, rests at 1 |
| cfg_data_bits | input | 2 | Data bit count minus 5 |
| cfg_parity | input | 2 | 0/3 none, 1 even, 2 odd |
| cfg_two_stop | input | 1 | 1 selects two stop bits |
| char_data | output | 8 | Received character, zero-extended |
| char_valid | output | 1 | One-clock strobe for a complete character |
| parity_err | output | 1 | Parity mismatch, valid with the strobe |
| frame_err | output | 1 | Stop element sampled as 0, valid with the strobe |

## Verification
The strobe is registered on the clock edge where the last stop bit is sampled. Counting the two synchroniser flops and up to one tick period of wait before detection, it appears between 48F−21 and 48F−19 clock edges after the start edge is driven, where the tick period is three clocks. The bench counts rising edges from the falling edge at which it drives the start bit to the falling edge at which it first sees the strobe, and checks that count against that window. Results that must not appear (a rejected glitch, a held break) are checked by watching the strobe over a window of 10 to 20 bit times after the stimulus. All outputs are read on falling edges, half a clock away from the edge that updates them.

// File: rtl/rxc_pkg.sv
package rxc_pkg;

  localparam int CHAR_W = 8;   // widest character
  localparam int MIN_W  = 5;   // narrowest character

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_PAR,
    RX_STOP,
    RX_HOLD
  } rx_state_t;

  // Data bit count from the 2-bit width code.
  function automatic logic [3:0] char_width(input logic [1:0] sel);
    return 4'(MIN_W) + {2'b00, sel};
  endfunction

  // Mask covering the lowest w bits.
  function automatic logic [CHAR_W-1:0] width_mask(input logic [3:0] w);
    logic [CHAR_W:0] oh;
    oh = (CHAR_W+1)'(1) << w;
    return CHAR_W'(oh - (CHAR_W+1)'(1));
  endfunction

  // Parity bit value the sender must use for a correct character.
  function automatic logic parity_bit(input logic [CHAR_W-1:0] d,
                                      input logic [3:0] w,
                                      input logic odd);
    return (^(d & width_mask(w))) ^ odd;
  endfunction

  function automatic logic parity_on(input logic [1:0] mode);
    return (mode == 2'b01) || (mode == 2'b10);
  endfunction

endpackage

// File: rtl/rxc_line_sync.sv
module rxc_line_sync #(
  parameter int   STAGES   = 2,
  parameter logic IDLE_LVL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] pipe;

  always_ff @(posedge clk) begin
    if (!rst_n) pipe <= {STAGES{IDLE_LVL}};
    else        pipe <= STAGES'({pipe, din});
  end

  assign dout = pipe[STAGES-1];
endmodule

// File: rtl/rxc_sample_timer.sv
module rxc_sample_timer #(
  parameter int OVS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic restart,
  input  logic half_phase,
  output logic sample_now
);
  localparam int CW = $clog2(OVS);
  localparam logic [CW-1:0] FULL_LAST = CW'(OVS - 1);
  localparam logic [CW-1:0] HALF_LAST = CW'(OVS / 2 - 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] limit;

  assign limit      = half_phase ? HALF_LAST : FULL_LAST;
  assign sample_now = tick && !restart && (cnt == limit);

  always_ff @(posedge clk) begin
    if (!rst_n)        cnt <= '0;
    else if (restart)  cnt <= '0;
    else if (tick)     cnt <= sample_now ? '0 : cnt + 1'b1;
  end
endmodule

// File: rtl/async_char_rx.sv
module async_char_rx
  import rxc_pkg::*;
#(
  parameter int OVS         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              os_tick,
  input  logic              rxd_in,
  input  logic [1:0]        cfg_data_bits,
  input  logic [1:0]        cfg_parity,
  input  logic              cfg_two_stop,
  output logic [CHAR_W-1:0] char_data,
  output logic              char_valid,
  output logic              parity_err,
  output logic              frame_err
);
  localparam int IDX_W = $clog2(CHAR_W);

  rx_state_t         state;
  logic              rx_line;
  logic [3:0]        width_q;
  logic              par_en_q, par_odd_q, two_stop_q;
  logic [IDX_W-1:0]  bit_idx;
  logic              stop_idx;
  logic [CHAR_W-1:0] shift_q;
  logic              par_bad, ferr_acc;

  // Named events, also watched by the checker.
  logic start_seen, sample_now, start_reject, in_wait;
  logic last_data, last_stop, stop_low;

  rxc_line_sync #(.STAGES(SYNC_STAGES), .IDLE_LVL(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(rxd_in), .dout(rx_line)
  );

  rxc_sample_timer #(.OVS(OVS)) u_timer (
    .clk(clk), .rst_n(rst_n), .tick(os_tick), .restart(start_seen),
    .half_phase(state == RX_START), .sample_now(sample_now)
  );

  assign start_seen   = (state == RX_IDLE) && os_tick && !rx_line;
  assign start_reject = (state == RX_START) && sample_now && rx_line;
  assign in_wait      = (state == RX_HOLD);
  assign last_data    = ({1'b0, bit_idx} == (width_q - 4'd1));
  assign last_stop    = (stop_idx == two_stop_q);
  assign stop_low     = !rx_line;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= RX_IDLE;
      width_q    <= 4'(CHAR_W);
      par_en_q   <= 1'b0;
      par_odd_q  <= 1'b0;
      two_stop_q <= 1'b0;
      bit_idx    <= '0;
      stop_idx   <= 1'b0;
      shift_q    <= '0;
      par_bad    <= 1'b0;
      ferr_acc   <= 1'b0;
      char_data  <= '0;
      char_valid <= 1'b0;
      parity_err <= 1'b0;
      frame_err  <= 1'b0;
    end else begin
      char_valid <= 1'b0;
      parity_err <= 1'b0;
      frame_err  <= 1'b0;
      case (state)
        RX_IDLE: begin
          if (start_seen) begin
            state      <= RX_START;
            width_q    <= char_width(cfg_data_bits);
            par_en_q   <= parity_on(cfg_parity);
            par_odd_q  <= (cfg_parity == 2'b10);
            two_stop_q <= cfg_two_stop;
            bit_idx    <= '0;
            stop_idx   <= 1'b0;
            shift_q    <= '0;
            par_bad    <= 1'b0;
            ferr_acc   <= 1'b0;
          end
        end
        RX_START: begin
          if (sample_now) state <= rx_line ? RX_IDLE : RX_DATA;
        end
        RX_DATA: begin
          if (sample_now) begin
            shift_q[bit_idx] <= rx_line;
            bit_idx          <= bit_idx + 1'b1;
            if (last_data) state <= par_en_q ? RX_PAR : RX_STOP;
          end
        end
        RX_PAR: begin
          if (sample_now) begin
            par_bad <= (rx_line != parity_bit(shift_q, width_q, par_odd_q));
            state   <= RX_STOP;
          end
        end
        RX_STOP: begin
          if (sample_now) begin
            if (last_stop) begin
              char_valid <= 1'b1;
              char_data  <= shift_q;
              parity_err <= par_bad;
              frame_err  <= ferr_acc | stop_low;
              state      <= (ferr_acc | stop_low) ? RX_HOLD : RX_IDLE;
            end else begin
              ferr_acc <= ferr_acc | stop_low;
              stop_idx <= 1'b1;
            end
          end
        end
        RX_HOLD: begin
          if (os_tick && rx_line) state <= RX_IDLE;
        end
        default: state <= RX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rxc_checker.sv
module rxc_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       os_tick,
  input logic       rx_line,
  input logic       char_valid,
  input logic       parity_err,
  input logic       frame_err,
  input logic [7:0] char_data,
  input logic [3:0] width_q,
  input logic       in_wait,
  input logic       start_reject
);
  // R6: the strobe never lasts two clocks
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    char_valid |=> !char_valid);

  // R6: error flags only ride on the strobe
  a_r6_flags_with_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (parity_err || frame_err) |-> char_valid);

  // R4 / R8: a framing error always leaves the receiver in the hold state
  a_r4_ferr_holds: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |-> in_wait);

  // R8: hold is only left after the line is sampled high on a tick
  a_r8_hold_until_high: assert property (@(posedge clk) disable iff (!rst_n)
    (in_wait && !(os_tick && rx_line)) |=> in_wait);

  // R5: a rejected start never yields a character next clock
  a_r5_reject_silent: assert property (@(posedge clk) disable iff (!rst_n)
    start_reject |=> !char_valid);

  // R2: bits above the captured width are clear
  a_r2_upper_clear: assert property (@(posedge clk) disable iff (!rst_n)
    char_valid |-> ((char_data >> width_q) == 8'h00));
endmodule

bind async_char_rx rxc_checker u_chk (
  .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rx_line(rx_line),
  .char_valid(char_valid), .parity_err(parity_err), .frame_err(frame_err),
  .char_data(char_data), .width_q(width_q), .in_wait(in_wait),
  .start_reject(start_reject)
);

// File: tb/tb_async_char_rx.sv
`timescale 1ns/1ps
module tb_async_char_rx;
  localparam int TDIV   = 3;
  localparam int OVS    = 16;
  localparam int BITCLK = TDIV * OVS;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       os_tick = 1'b0;
  logic       rxd_in = 1'b1;
  logic [1:0] cfg_data_bits = 2'd3;
  logic [1:0] cfg_parity = 2'd0;
  logic       cfg_two_stop = 1'b0;
  logic [7:0] char_data;
  logic       char_valid, parity_err, frame_err;

  async_char_rx dut (
    .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rxd_in(rxd_in),
    .cfg_data_bits(cfg_data_bits), .cfg_parity(cfg_parity),
    .cfg_two_stop(cfg_two_stop), .char_data(char_data),
    .char_valid(char_valid), .parity_err(parity_err), .frame_err(frame_err)
  );

  always #2.5 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  int cyc = 0, tdiv = 0;
  int got_n = 0, got_cyc = 0, last_start = 0;
  logic [7:0] got_data = 8'h00;
  logic got_pe = 1'b0, got_fe = 1'b0, prev_v = 1'b0, wide = 1'b0;
  bit done = 0;

  initial forever begin @(posedge clk); cyc++; end

  initial forever begin
    @(negedge clk);
    os_tick = (tdiv == 0);
    tdiv = (tdiv == TDIV - 1) ? 0 : tdiv + 1;
  end

  initial forever begin
    @(negedge clk);
    if (char_valid) begin
      got_n++;
      got_data = char_data;
      got_pe   = parity_err;
      got_fe   = frame_err;
      got_cyc  = cyc;
      if (prev_v) wide = 1'b1;
    end
    prev_v = char_valid;
  end

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  function automatic bit ones_odd(input logic [7:0] d, input int nb);
    bit r = 0;
    for (int i = 0; i < nb; i++) r ^= d[i];
    return r;
  endfunction

  task automatic drive_bit(input logic v);
    rxd_in = v;
    repeat (BITCLK) @(negedge clk);
  endtask

  task automatic idle_bits(input int n);
    rxd_in = 1'b1;
    repeat (n * BITCLK) @(negedge clk);
  endtask

  // pm: 0/3 none, 1 even, 2 odd
  task automatic send_char(input logic [7:0] d, input int nb, input int pm,
                           input bit two, input bit flip, input logic s1,
                           input logic s2, input bit chg);
    cfg_data_bits = 2'(nb - 5);
    cfg_parity    = 2'(pm);
    cfg_two_stop  = two;
    last_start    = cyc;
    drive_bit(1'b0);
    if (chg) begin
      cfg_data_bits = 2'd0;
      cfg_parity    = 2'd2;
      cfg_two_stop  = 1'b1;
    end
    for (int i = 0; i < nb; i++) drive_bit(d[i]);
    if (pm == 1 || pm == 2) drive_bit(ones_odd(d, nb) ^ (pm == 2) ^ flip);
    drive_bit(s1);
    if (two) drive_bit(s2);
  endtask

  task automatic expect_char(input string tag, input logic [7:0] d, input int nb,
                             input int pm, input bit two, input bit pe,
                             input bit fe, input int n_before);
    int f;
    int lat;
    logic [7:0] m;
    m   = 8'((9'd1 << nb) - 9'd1);
    f   = 1 + nb + ((pm == 1 || pm == 2) ? 1 : 0) + (two ? 2 : 1);
    lat = got_cyc - last_start;
    chk(got_n == n_before + 1, {tag, " strobe count"}, got_n, n_before + 1);
    chk(got_data == (d & m), {tag, " data R2"}, got_data, d & m);
    chk(got_pe == pe, {tag, " parity flag R3"}, got_pe, pe);
    chk(got_fe == fe, {tag, " framing flag R4"}, got_fe, fe);
    chk(lat >= 48 * f - 21 && lat <= 48 * f - 19, {tag, " latency R7"}, lat, 48 * f - 20);
    chk(!wide, {tag, " single clock strobe R6"}, wide, 0);
  endtask

  task automatic t_reset();
    chk(char_valid == 1'b0, "R1 valid in reset", char_valid, 0);
    chk(parity_err == 1'b0, "R1 parity flag in reset", parity_err, 0);
    chk(frame_err == 1'b0,  "R1 framing flag in reset", frame_err, 0);
    chk(char_data == 8'h00, "R1 data in reset", char_data, 0);
  endtask

  task automatic t_formats();
    int n;
    n = got_n; send_char(8'hA5, 8, 0, 0, 0, 1, 1, 0);
    expect_char("8N1", 8'hA5, 8, 0, 0, 0, 0, n); idle_bits(2);
    n = got_n; send_char(8'hFF, 5, 0, 1, 0, 1, 1, 0);
    expect_char("5N2", 8'hFF, 5, 0, 1, 0, 0, n); idle_bits(2);
    n = got_n; send_char(8'h2D, 6, 1, 0, 0, 1, 1, 0);
    expect_char("6E1 R3", 8'h2D, 6, 1, 0, 0, 0, n); idle_bits(2);
    n = got_n; send_char(8'h55, 7, 2, 1, 0, 1, 1, 0);
    expect_char("7O2 R3", 8'h55, 7, 2, 1, 0, 0, n); idle_bits(2);
    n = got_n; send_char(8'h3C, 8, 3, 0, 0, 1, 1, 0);
    expect_char("8 code3 none R3", 8'h3C, 8, 3, 0, 0, 0, n); idle_bits(2);
  endtask

  task automatic t_parity_err();
    int n;
    n = got_n; send_char(8'h81, 8, 1, 0, 1, 1, 1, 0);
    expect_char("even bad R3", 8'h81, 8, 1, 0, 1, 0, n); idle_bits(2);
    n = got_n; send_char(8'h16, 6, 2, 0, 1, 1, 1, 0);
    expect_char("odd bad R3", 8'h16, 6, 2, 0, 1, 0, n); idle_bits(2);
  endtask

  task automatic t_frame();
    int n;
    n = got_n; send_char(8'h7E, 8, 0, 0, 0, 0, 1, 0);
    expect_char("stop low R4", 8'h7E, 8, 0, 0, 0, 1, n);
    n = got_n;
    rxd_in = 1'b0;
    repeat (20 * BITCLK) @(negedge clk);
    chk(got_n == n, "R8 break held after framing error", got_n, n);
    idle_bits(2);
    n = got_n; send_char(8'h42, 8, 0, 0, 0, 1, 1, 0);
    expect_char("after break R8", 8'h42, 8, 0, 0, 0, 0, n); idle_bits(2);
    n = got_n; send_char(8'h19, 5, 0, 1, 0, 1, 0, 0);
    expect_char("second stop low R4", 8'h19, 5, 0, 1, 0, 1, n); idle_bits(2);
    n = got_n; send_char(8'h0F, 7, 1, 1, 0, 0, 1, 0);
    expect_char("first stop low R4", 8'h0F, 7, 1, 1, 0, 1, n); idle_bits(2);
  endtask

  task automatic t_glitch();
    int n;
    n = got_n;
    rxd_in = 1'b0;
    repeat (2 * TDIV) @(negedge clk);
    idle_bits(12);
    chk(got_n == n, "R5 glitch produced no character", got_n, n);
    n = got_n; send_char(8'hC9, 8, 2, 0, 0, 1, 1, 0);
    expect_char("after glitch R5", 8'hC9, 8, 2, 0, 0, 0, n); idle_bits(2);
  endtask

  task automatic t_b2b();
    int n;
    n = got_n; send_char(8'h5A, 8, 0, 0, 0, 1, 1, 0);
    expect_char("b2b first R9", 8'h5A, 8, 0, 0, 0, 0, n);
    n = got_n; send_char(8'hC3, 8, 0, 0, 0, 1, 1, 0);
    expect_char("b2b second R9", 8'hC3, 8, 0, 0, 0, 0, n);
    n = got_n; send_char(8'h0A, 5, 1, 0, 0, 1, 1, 0);
    expect_char("b2b third R9", 8'h0A, 5, 1, 0, 0, 0, n); idle_bits(2);
  endtask

  task automatic t_cfg_change();
    int n;
    n = got_n; send_char(8'hB7, 8, 0, 0, 0, 1, 1, 1);
    expect_char("cfg moved mid char R10", 8'hB7, 8, 0, 0, 0, 0, n);
    idle_bits(3);
  endtask

  initial begin
    rst_n = 1'b0;
    repeat (6) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_formats();
    t_parity_err();
    t_frame();
    t_glitch();
    t_b2b();
    t_cfg_change();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule